// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the entry step of exception handling in a small 32-bit RISC core. The core presents a single-cycle request with a cause code, the PC of the affected instruction, the pending branch target and the pipeline state: whether the instruction sits in a branch delay slot, whether it follows an immediate prefix, and whether the branch itself had one. On the next clock edge the block commits every effect of the entry together. These are the new program counter, the general-register write of the return address, the saved and updated machine status register, and, for translation faults, the fault status, fault address and branch-target capture.

Four causes are handled: memory-translation fault, external interrupt, software break and hardware break. The return address is rewound so that an interrupted branch or prefix sequence is executed again. The status register keeps a copy of the user-mode and virtual-memory bits by shifting each one up a position. The core's normal status-write path can load the register whenever no entry is committing. A second translation fault that arrives while one is still in progress does not re-enter. It sets a sticky fatal-error output instead.

Top module: `exc_entry`

## Requirements
- R1: A translation-fault request (cause 0) causes `exc_new_pc` = 0x20 and writes the return address into general register 17 (`link_idx` = 17, `link_we` = 1).
- R2: An interrupt request (cause 1) is taken only when status bit 1 (interrupt enable) is 1, bit 3 (break in progress) is 0, bit 9 (exception in progress) is 0 and `req_in_dslot` is 0. A taken interrupt jumps to 0x10, writes the PC into register 14 and clears bit 1. A refused interrupt changes no output and no register.
- R3: A hardware break (cause 3) jumps to 0x18 and writes the PC into register 16. A software break (cause 2) jumps to `req_btarget` and writes no register. Both set status bit 3.
- R4: On every taken entry, user-mode bit 11 is copied to bit 12 and virtual-memory bit 13 is copied to bit 14, after which bits 11 and 13 are cleared.
- R5: A taken translation fault sets status bit 9 and pulses `clr_iflags` for one cycle. Other causes leave `clr_iflags` at 0.
- R6: The return address of a translation fault is the PC minus 4 in a delay slot, minus 8 in a delay slot whose branch had an immediate prefix, minus 4 after an immediate prefix outside a delay slot, and the PC itself otherwise.
- R7: The fault status written on a translation fault is 16 for a protection fault on data, 17 for a protection fault on fetch, 18 for a miss on data and 19 for a miss on fetch. Bit 10 is set for a store and bit 12 is set in a delay slot. In a delay slot, `btr` takes `req_btarget`.
- R8: A translation fault captures `fault_addr` into `ear`. Other causes leave `ear` and `esr` unchanged.
- R9: A translation fault arriving while status bit 9 is set causes no entry and sets `fatal_err`, which stays at 1 until reset.
- R10: All effects appear in the cycle after the request. `exc_taken` is high for exactly that one cycle per taken request.
- R11: After reset, `msr`, `esr`, `ear`, `btr`, `exc_taken`, `link_we`, `clr_iflags` and `fatal_err` are all 0.
- R12: `msr_wr_en` loads `msr_wr_data` into the status register on the next edge, unless an entry commits on that edge, in which case the entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle entry request |
| req_cause | input | 2 | 0 fault, 1 interrupt, 2 software break, 3 hardware break |
| req_pc | input | 32 | PC of the affected instruction |
| req_btarget | input | 32 | Pending branch target |
| req_in_dslot | input | 1 | Instruction is in a branch delay slot |
| req_after_imm | input | 1 | Instruction follows an immediate prefix |
| req_branch_imm | input | 1 | The delay-slot branch had an immediate prefix |
| fault_is_miss | input | 1 | 1 = translation miss, 0 = protection fault |
| fault_on_fetch | input | 1 | Fault was on instruction fetch |
| fault_on_store | input | 1 | Faulting access was a store |
| fault_addr | input | 32 | Faulting address |
| msr_wr_en | input | 1 | Status register load from the core |
| msr_wr_data | input | 32 | Value for the status register load |
| exc_taken | output | 1 | One-cycle pulse: entry committed |
| exc_new_pc | output | 32 | Target PC of the last entry |
| link_we | output | 1 | General-register write enable for the return address |
| link_idx | output | 5 | General register to write |
| link_data | output | 32 | Return address |
| clr_iflags | output | 1 | Clear the core's prefix and delay-slot flags |
| msr | output | 32 | Machine status register |
| esr | output | 32 | Fault status register |
| ear | output | 32 | Fault address register |
| btr | output | 32 | Branch target register |
| fatal_err | output | 1 | Sticky nested-fault error |

## Verification
Every effect of an entry is registered, so a wrong decode of the cause or the rewind shows on `exc_new_pc`, `link_idx` or `link_data` in the cycle after the request. A bad status-register update is visible on `msr` at that same edge. A status register that is wrongly updated or left stale changes the result of the next request: an interrupt is refused or accepted when it should not be, or a fault raises `fatal_err` instead of entering. A refused request leaves all outputs as they were.

// File: rtl/exc_pkg.sv
// Package: shared cause codes and bit positions for the exception entry block.
// Assumes a 32-bit status register; positions chosen so saved copies sit one bit above.
package exc_pkg;

    typedef enum logic [1:0] {
        CAUSE_MMU   = 2'd0,
        CAUSE_IRQ   = 2'd1,
        CAUSE_SWBRK = 2'd2,
        CAUSE_HWBRK = 2'd3
    } cause_e;

    // status register bit positions
    localparam int ST_IE  = 1;
    localparam int ST_BIP = 3;
    localparam int ST_EIP = 9;
    localparam int ST_UM  = 11;
    localparam int ST_VM  = 13;

    // mode bits preserved on entry; each saved copy sits at position + 1
    localparam int N_MODE = 2;
    localparam int MODE_POS [N_MODE] = '{ST_UM, ST_VM};

    // fault status fields
    localparam int FS_STORE_BIT = 10;
    localparam int FS_DSLOT_BIT = 12;
    localparam int FS_CODE_W    = 5;
    localparam logic [FS_CODE_W-1:0] FS_PROT_BASE = 5'd16;
    localparam logic [FS_CODE_W-1:0] FS_MISS_BASE = 5'd18;

endpackage

// File: rtl/exc_route.sv
// Module: exc_route
// Picks vector, link register and acceptance per cause. Purely combinational.
// Assumes the status bits come from the current registered status value.
module exc_route
    import exc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int RIDX_W    = 5,
    parameter logic [XLEN-1:0] VEC_MMU = 32'h20,
    parameter logic [XLEN-1:0] VEC_IRQ = 32'h10,
    parameter logic [XLEN-1:0] VEC_HWB = 32'h18,
    parameter logic [RIDX_W-1:0] LNK_MMU = 5'd17,
    parameter logic [RIDX_W-1:0] LNK_IRQ = 5'd14,
    parameter logic [RIDX_W-1:0] LNK_HWB = 5'd16
) (
    input  cause_e            cause,
    input  logic [XLEN-1:0]   btarget,
    input  logic              st_ie,
    input  logic              st_bip,
    input  logic              st_eip,
    input  logic              in_dslot,
    output logic              eligible,
    output logic              nested_fault,
    output logic [XLEN-1:0]   vector,
    output logic              lnk_we,
    output logic [RIDX_W-1:0] lnk_idx
);

    // Per-cause selection of target, link register and gating.
    always_comb begin
        eligible     = 1'b0;
        nested_fault = 1'b0;
        vector       = '0;
        lnk_we       = 1'b0;
        lnk_idx      = '0;
        unique case (cause)
            CAUSE_MMU: begin
                eligible     = !st_eip;
                nested_fault = st_eip;
                vector       = VEC_MMU;
                lnk_we       = 1'b1;
                lnk_idx      = LNK_MMU;
            end
            CAUSE_IRQ: begin
                eligible = st_ie && !st_bip && !st_eip && !in_dslot;
                vector   = VEC_IRQ;
                lnk_we   = 1'b1;
                lnk_idx  = LNK_IRQ;
            end
            CAUSE_SWBRK: begin
                eligible = 1'b1;
                vector   = btarget;
            end
            CAUSE_HWBRK: begin
                eligible = 1'b1;
                vector   = VEC_HWB;
                lnk_we   = 1'b1;
                lnk_idx  = LNK_HWB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_retaddr.sv
// Module: exc_retaddr
// Computes the return address so an interrupted branch/prefix sequence re-executes.
// Assumes fixed-size instructions of INSN_BYTES; rewind applies to faults only.
module exc_retaddr #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic            is_fault,
    input  logic [XLEN-1:0] pc,
    input  logic            in_dslot,
    input  logic            after_imm,
    input  logic            branch_imm,
    output logic [XLEN-1:0] ret_addr
);

    localparam logic [XLEN-1:0] ONE_STEP = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] TWO_STEP = XLEN'(2 * INSN_BYTES);

    logic [XLEN-1:0] rewind;

    // Rewind distance by pipeline state.
    always_comb begin
        rewind = '0;
        if (is_fault) begin
            if (in_dslot)
                rewind = branch_imm ? TWO_STEP : ONE_STEP;
            else if (after_imm)
                rewind = ONE_STEP;
        end
    end

    // Apply the rewind.
    assign ret_addr = pc - rewind;

endmodule

// File: rtl/exc_status_upd.sv
// Module: exc_status_upd
// Builds the next status value and the fault status word for an entry.
// Assumes MODE_POS entries leave room for a saved copy one position higher.
module exc_status_upd
    import exc_pkg::*;
#(
    parameter int ST_W = 32,
    parameter int FS_W = 32
) (
    input  cause_e          cause,
    input  logic [ST_W-1:0] st_cur,
    input  logic            is_miss,
    input  logic            on_fetch,
    input  logic            on_store,
    input  logic            in_dslot,
    output logic [ST_W-1:0] st_next,
    output logic [FS_W-1:0] fs_next
);

    logic [ST_W-1:0] st_saved;

    // Shift each mode bit into its saved slot and clear the live bit.
    always_comb begin
        st_saved = st_cur;
        for (int k = 0; k < N_MODE; k++) begin
            st_saved[MODE_POS[k] + 1] = st_cur[MODE_POS[k]];
            st_saved[MODE_POS[k]]     = 1'b0;
        end
    end

    // Cause-specific enable and in-progress bits.
    always_comb begin
        st_next = st_saved;
        unique case (cause)
            CAUSE_MMU:   st_next[ST_EIP] = 1'b1;
            CAUSE_IRQ:   st_next[ST_IE]  = 1'b0;
            CAUSE_SWBRK: st_next[ST_BIP] = 1'b1;
            CAUSE_HWBRK: st_next[ST_BIP] = 1'b1;
            default: ;
        endcase
    end

    // Fault status word: base code plus fetch, store and delay-slot marks.
    always_comb begin
        fs_next = '0;
        fs_next[FS_CODE_W-1:0] = (is_miss ? FS_MISS_BASE : FS_PROT_BASE)
                                 + {{(FS_CODE_W-1){1'b0}}, on_fetch};
        fs_next[FS_STORE_BIT]  = on_store;
        fs_next[FS_DSLOT_BIT]  = in_dslot;
    end

endmodule

// File: rtl/exc_entry.sv
// Module: exc_entry (top)
// Commits an exception entry on one clock edge: new PC, return-address write,
// status save, fault status/address/branch-target capture, nested-fault error.
// Assumes req_* fields are valid only while req_valid is high; synchronous active-low reset.
module exc_entry
    import exc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int RIDX_W     = 5,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cause,
    input  logic [XLEN-1:0]   req_pc,
    input  logic [XLEN-1:0]   req_btarget,
    input  logic              req_in_dslot,
    input  logic              req_after_imm,
    input  logic              req_branch_imm,
    input  logic              fault_is_miss,
    input  logic              fault_on_fetch,
    input  logic              fault_on_store,
    input  logic [XLEN-1:0]   fault_addr,
    input  logic              msr_wr_en,
    input  logic [XLEN-1:0]   msr_wr_data,
    output logic              exc_taken,
    output logic [XLEN-1:0]   exc_new_pc,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_data,
    output logic              clr_iflags,
    output logic [XLEN-1:0]   msr,
    output logic [XLEN-1:0]   esr,
    output logic [XLEN-1:0]   ear,
    output logic [XLEN-1:0]   btr,
    output logic              fatal_err
);

    cause_e            cause;
    logic              eligible;
    logic              nested_fault;
    logic [XLEN-1:0]   vector;
    logic              r_lnk_we;
    logic [RIDX_W-1:0] r_lnk_idx;
    logic [XLEN-1:0]   ret_addr;
    logic [XLEN-1:0]   st_next;
    logic [XLEN-1:0]   fs_next;
    logic              accept;
    logic              is_fault;

    assign cause    = cause_e'(req_cause);
    assign is_fault = (cause == CAUSE_MMU);

    exc_route #(
        .XLEN   (XLEN),
        .RIDX_W (RIDX_W)
    ) u_route (
        .cause        (cause),
        .btarget      (req_btarget),
        .st_ie        (msr[ST_IE]),
        .st_bip       (msr[ST_BIP]),
        .st_eip       (msr[ST_EIP]),
        .in_dslot     (req_in_dslot),
        .eligible     (eligible),
        .nested_fault (nested_fault),
        .vector       (vector),
        .lnk_we       (r_lnk_we),
        .lnk_idx      (r_lnk_idx)
    );

    exc_retaddr #(
        .XLEN       (XLEN),
        .INSN_BYTES (INSN_BYTES)
    ) u_retaddr (
        .is_fault   (is_fault),
        .pc         (req_pc),
        .in_dslot   (req_in_dslot),
        .after_imm  (req_after_imm),
        .branch_imm (req_branch_imm),
        .ret_addr   (ret_addr)
    );

    exc_status_upd #(
        .ST_W (XLEN),
        .FS_W (XLEN)
    ) u_status (
        .cause    (cause),
        .st_cur   (msr),
        .is_miss  (fault_is_miss),
        .on_fetch (fault_on_fetch),
        .on_store (fault_on_store),
        .in_dslot (req_in_dslot),
        .st_next  (st_next),
        .fs_next  (fs_next)
    );

    assign accept = req_valid && eligible;

    // Per-entry pulses: taken, link write, flag clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_taken  <= 1'b0;
            link_we    <= 1'b0;
            clr_iflags <= 1'b0;
        end else begin
            exc_taken  <= accept;
            link_we    <= accept && r_lnk_we;
            clr_iflags <= accept && is_fault;
        end
    end

    // Entry target and return-address payload, held between entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_new_pc <= '0;
            link_idx   <= '0;
            link_data  <= '0;
        end else if (accept) begin
            exc_new_pc <= vector;
            link_idx   <= r_lnk_idx;
            link_data  <= ret_addr;
        end
    end

    // Status register: entry update wins over the core's load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            msr <= '0;
        else if (accept)
            msr <= st_next;
        else if (msr_wr_en)
            msr <= msr_wr_data;
    end

    // Fault status and fault address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esr <= '0;
            ear <= '0;
        end else if (accept && is_fault) begin
            esr <= fs_next;
            ear <= fault_addr;
        end
    end

    // Branch target capture for a fault inside a delay slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            btr <= '0;
        else if (accept && is_fault && req_in_dslot)
            btr <= req_btarget;
    end

    // Sticky nested-fault error.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fatal_err <= 1'b0;
        else if (req_valid && nested_fault)
            fatal_err <= 1'b1;
    end

endmodule

// File: rtl/exc_entry_chk.sv
// Module: exc_entry_chk
// Temporal checks on exc_entry ports, attached by bind below.
// Assumes synchronous active-low reset; all checks disabled while in reset.
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_cause,
    input logic              req_in_dslot,
    input logic [XLEN-1:0]   msr,
    input logic              exc_taken,
    input logic [XLEN-1:0]   exc_new_pc,
    input logic              link_we,
    input logic [RIDX_W-1:0] link_idx,
    input logic              clr_iflags,
    input logic              fatal_err
);

    // R10
    taken_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> $past(req_valid));

    // R2
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cause == 2'd1 && (!msr[ST_IE] || msr[ST_EIP] || msr[ST_BIP] || req_in_dslot))
        |=> !exc_taken);

    // R4
    mode_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (!msr[ST_UM] && !msr[ST_VM]));

    // R1
    fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cause == 2'd0 && !msr[ST_EIP])
        |=> (exc_taken && exc_new_pc == 32'h20 && link_we && link_idx == 5'd17));

    // R5
    fault_eip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_iflags |-> (exc_taken && msr[ST_EIP]));

    // R9
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |=> fatal_err);

    // R9
    nested_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cause == 2'd0 && msr[ST_EIP]) |=> (!exc_taken && fatal_err));

endmodule

bind exc_entry exc_entry_chk #(
    .XLEN   (XLEN),
    .RIDX_W (RIDX_W)
) u_exc_entry_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_cause    (req_cause),
    .req_in_dslot (req_in_dslot),
    .msr          (msr),
    .exc_taken    (exc_taken),
    .exc_new_pc   (exc_new_pc),
    .link_we      (link_we),
    .link_idx     (link_idx),
    .clr_iflags   (clr_iflags),
    .fatal_err    (fatal_err)
);

// File: tb/test_exc_entry.sv
// Bench for exc_entry: table-driven entries, then directed reset, gating and nested-fault tests.
module test_exc_entry;

    localparam int XLEN = 32;
    localparam logic [31:0] PC0 = 32'h0000_1000;
    localparam logic [31:0] BT0 = 32'h0000_2000;

    typedef struct packed {
        logic [1:0]  cause;
        logic        dslot;
        logic        aimm;
        logic        bimm;
        logic        miss;
        logic        fetch;
        logic        store;
        logic [31:0] preload;
        logic [31:0] exp_pc;
        logic        exp_lwe;
        logic [4:0]  exp_lidx;
        logic [31:0] exp_link;
        logic [31:0] exp_esr;
        logic [31:0] exp_msr;
    } vec_t;

    localparam int NVEC = 7;
    // R1 R4 R5 R6 R7 rows 0-3; R2 row 4; R3 rows 5-6
    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h2800, 32'h20, 1'b1, 5'd17, 32'h1000, 32'h0012, 32'h5200},
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000, 32'h20, 1'b1, 5'd17, 32'h0FFC, 32'h1410, 32'h0200},
        '{2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h2000, 32'h20, 1'b1, 5'd17, 32'h0FF8, 32'h1013, 32'h4200},
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0800, 32'h20, 1'b1, 5'd17, 32'h0FFC, 32'h0011, 32'h1200},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2802, 32'h10, 1'b1, 5'd14, 32'h1000, 32'h0011, 32'h5000},
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0802, 32'h18, 1'b1, 5'd16, 32'h1000, 32'h0011, 32'h100A},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2000, 32'h2000, 1'b0, 5'd0, 32'h0, 32'h0011, 32'h4008}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_in_dslot, req_after_imm, req_branch_imm;
    logic [1:0]  req_cause;
    logic [31:0] req_pc, req_btarget, fault_addr, msr_wr_data;
    logic        fault_is_miss, fault_on_fetch, fault_on_store, msr_wr_en;
    logic        exc_taken, link_we, clr_iflags, fatal_err;
    logic [31:0] exc_new_pc, link_data, msr, esr, ear, btr;
    logic [4:0]  link_idx;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    exc_entry i_exc_entry (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cause(req_cause),
        .req_pc(req_pc), .req_btarget(req_btarget), .req_in_dslot(req_in_dslot),
        .req_after_imm(req_after_imm), .req_branch_imm(req_branch_imm),
        .fault_is_miss(fault_is_miss), .fault_on_fetch(fault_on_fetch),
        .fault_on_store(fault_on_store), .fault_addr(fault_addr),
        .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
        .exc_taken(exc_taken), .exc_new_pc(exc_new_pc), .link_we(link_we),
        .link_idx(link_idx), .link_data(link_data), .clr_iflags(clr_iflags),
        .msr(msr), .esr(esr), .ear(ear), .btr(btr), .fatal_err(fatal_err)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_cause = 0; req_pc = PC0; req_btarget = BT0;
        req_in_dslot = 0; req_after_imm = 0; req_branch_imm = 0;
        fault_is_miss = 0; fault_on_fetch = 0; fault_on_store = 0;
        fault_addr = 0; msr_wr_en = 0; msr_wr_data = 0;
    endtask

    // R12: load status through the core's write path
    task automatic load_msr(input logic [31:0] v);
        @(negedge clk);
        msr_wr_en = 1; msr_wr_data = v;
        @(negedge clk);
        msr_wr_en = 0;
    endtask

    task automatic send(input logic [1:0] c, input logic ds, input logic ai, input logic bi,
                        input logic mi, input logic fe, input logic st, input logic [31:0] fa);
        @(negedge clk);
        req_valid = 1; req_cause = c; req_in_dslot = ds; req_after_imm = ai;
        req_branch_imm = bi; fault_is_miss = mi; fault_on_fetch = fe;
        fault_on_store = st; fault_addr = fa;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "msr", msr, 0);
        check("R11", "esr", esr, 0);
        check("R11", "ear", ear, 0);
        check("R11", "btr", btr, 0);
        check("R11", "taken", {31'b0, exc_taken}, 0);
        check("R11", "fatal", {31'b0, fatal_err}, 0);
        rst_n = 1;

        for (int i = 0; i < NVEC; i++) begin
            load_msr(TBL[i].preload);
            check("R12", "preload", msr, TBL[i].preload);
            send(TBL[i].cause, TBL[i].dslot, TBL[i].aimm, TBL[i].bimm,
                 TBL[i].miss, TBL[i].fetch, TBL[i].store, 32'hABC0_0000 + i);
            check("R10", "taken", {31'b0, exc_taken}, 1);
            check("R1/R2/R3", "new pc", exc_new_pc, TBL[i].exp_pc);
            check("R3", "link we", {31'b0, link_we}, {31'b0, TBL[i].exp_lwe});
            if (TBL[i].exp_lwe) begin
                check("R1", "link idx", {27'b0, link_idx}, {27'b0, TBL[i].exp_lidx});
                check("R6", "link data", link_data, TBL[i].exp_link);
            end
            check("R4", "msr", msr, TBL[i].exp_msr);
            check("R7", "esr", esr, TBL[i].exp_esr);
            check("R5", "clr flags", {31'b0, clr_iflags}, {31'b0, TBL[i].cause == 2'd0});
            if (TBL[i].cause == 2'd0)
                check("R8", "ear", ear, 32'hABC0_0000 + i);
            if (TBL[i].cause == 2'd0 && TBL[i].dslot)
                check("R7", "btr", btr, BT0);
            @(negedge clk);
            check("R10", "taken drops", {31'b0, exc_taken}, 0);
        end
        // R8: non-fault entries left ear at the last fault address (row 3)
        check("R8", "ear held", ear, 32'hABC0_0003);

        // R2 refused: IE clear
        load_msr(32'h2800);
        send(2'd1, 0, 0, 0, 0, 0, 0, 0);
        check("R2", "no take ie=0", {31'b0, exc_taken}, 0);
        check("R2", "msr kept ie=0", msr, 32'h2800);
        // R2 refused: break in progress
        load_msr(32'h000A);
        send(2'd1, 0, 0, 0, 0, 0, 0, 0);
        check("R2", "no take bip", {31'b0, exc_taken}, 0);
        check("R2", "msr kept bip", msr, 32'h000A);
        // R2 refused: delay slot
        load_msr(32'h0002);
        send(2'd1, 1, 0, 0, 0, 0, 0, 0);
        check("R2", "no take dslot", {31'b0, exc_taken}, 0);
        check("R2", "msr kept dslot", msr, 32'h0002);
        // R2 refused: exception in progress
        load_msr(32'h0202);
        send(2'd1, 0, 0, 0, 0, 0, 0, 0);
        check("R2", "no take eip", {31'b0, exc_taken}, 0);

        // R12: entry wins over a simultaneous status write
        @(negedge clk);
        msr_wr_en = 1; msr_wr_data = 32'hFFFF_0000;
        req_valid = 1; req_cause = 2'd3;
        @(negedge clk);
        idle_inputs();
        check("R12", "entry wins", msr, 32'h020A);

        // R9 nested fault: EIP set, fault arrives
        load_msr(32'h0200);
        send(2'd0, 0, 0, 0, 1, 0, 0, 32'h5555_0000);
        check("R9", "no entry", {31'b0, exc_taken}, 0);
        check("R9", "fatal set", {31'b0, fatal_err}, 1);
        check("R9", "ear kept", ear, 32'hABC0_0003);
        check("R9", "msr kept", msr, 32'h0200);
        repeat (3) @(negedge clk);
        check("R9", "fatal sticky", {31'b0, fatal_err}, 1);

        // R11 reset clears fatal
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check("R11", "fatal after reset", {31'b0, fatal_err}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule